// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single column request into the run of column addresses that a burst visits, one address per clock. A start pulse captures the requested column, a two-bit length code, an order-select bit and the access direction. From the next cycle on, the block presents one column per cycle on `col`, with `valid` high. `last` flags the final beat. Every burst stays inside an aligned block whose size is the burst length. The requested word always comes first. The columns that follow either count upward and wrap at the block boundary (sequential order) or are formed by XOR-ing the beat number into the low bits (interleaved order).

A terminate pulse cuts a burst short. A write-single control, when set, shrinks every write burst to one beat whatever length is programmed. The controller is a two-state machine. `ST_IDLE` moves to `ST_BURST` on a start. `ST_BURST` stays in `ST_BURST` on a start (restart with fresh parameters) or while beats remain. It returns to `ST_IDLE` on a terminate or after the final beat.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid` and `last` are 0.
- R2: A start pulse sampled at a clock edge makes `valid` 1 after that edge, with `col` equal to the requested column (critical word first).
- R3: The length code selects the beat count: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. `last` is 1 only on the final beat. `valid` falls the cycle after the final beat unless a new start arrives.
- R4: Every column of a burst of length N keeps all bits above bit log2(N)-1 equal to the requested column. With `ilv`=0 the low log2(N) bits of beat k are (start + k) mod N, so start 5 with length 4 gives 5-6-7-4.
- R5: With `ilv`=1 the low log2(N) bits of beat k are start XOR k, so start 5 with length 4 gives 5-4-7-6. A block-aligned start gives 0-1-2-...-7 in both orders.
- R6: A terminate pulse sampled while `valid` is 1 (and no start) makes `valid` and `last` 0 after that edge.
- R7: A terminate pulse while idle has no effect: `valid` stays 0.
- R8: A start pulse during a burst restarts it with the newly presented parameters, and takes priority over a terminate in the same cycle.
- R9: When `is_write`=1 and `wr_single`=1 at the start, the burst is one beat long regardless of the length code. With `is_write`=0 the length code applies unchanged.
- R10: Column, length, order and direction inputs are captured only at a start. Changing them mid-burst does not alter the remaining columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst with the presented parameters |
| term | input | 1 | End the running burst |
| start_col | input | COL_W | Requested column |
| len_code | input | 2 | Burst length code (00=1, 01=2, 10=4, 11=8) |
| ilv | input | 1 | 0 sequential order, 1 interleaved order |
| is_write | input | 1 | Access is a write |
| wr_single | input | 1 | Force write bursts to one beat |
| col | output | COL_W | Current column address |
| valid | output | 1 | `col` holds a beat of a burst |
| last | output | 1 | Current beat is the final one |

## Verification
The bench goes after unaligned starts near the top of a block. A design that propagated the carry would leave the aligned block, for example 7 becoming 8 instead of 4. It also checks the interleaved order against the sequential one: a swapped or ignored order bit makes start 5 give 5-6-7-4 where 5-4-7-6 is expected. Terminate and restart collisions, write-single forcing, and inputs changing mid-burst are exercised. A design that kept running, ignored the forced length, or read live inputs instead of captured ones would show a wrong `valid` or a wrong column on the following beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    // Beat counter width fixes the largest burst (2**BEAT_W words).
    localparam int BEAT_W = 3;

    typedef enum logic [1:0] {
        LEN_ONE   = 2'b00,
        LEN_TWO   = 2'b01,
        LEN_FOUR  = 2'b10,
        LEN_EIGHT = 2'b11
    } len_code_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
    import burst_col_pkg::*;
(
    input  logic [1:0]        len_code,
    input  logic              is_write,
    input  logic              wr_single,
    output logic [BEAT_W-1:0] wrap_mask
);
    logic [1:0] eff_code;

    // Forced single-beat writes collapse the code to one beat.
    always_comb begin
        if (is_write && wr_single) eff_code = LEN_ONE;
        else                       eff_code = len_code;
    end

    // Bit i of the mask is set when the burst spans more than 2**i words.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_mask
        assign wrap_mask[i] = (32'(eff_code) > i);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [BEAT_W-1:0] wrap_mask,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv,
    output logic [COL_W-1:0]  col
);
    logic [BEAT_W-1:0] seq_low;
    logic [BEAT_W-1:0] xor_low;
    logic [BEAT_W-1:0] pick_low;

    // Carries out of the low field are dropped by the field width itself.
    assign seq_low  = base_col[BEAT_W-1:0] + beat;
    assign xor_low  = base_col[BEAT_W-1:0] ^ beat;
    assign pick_low = ilv ? xor_low : seq_low;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_low
        assign col[i] = wrap_mask[i] ? pick_low[i] : base_col[i];
    end

    assign col[COL_W-1:BEAT_W] = base_col[COL_W-1:BEAT_W];
endmodule

// File: rtl/burst_col_fsm.sv
module burst_col_fsm
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              term,
    input  logic [COL_W-1:0]  start_col,
    input  logic [BEAT_W-1:0] dec_mask,
    input  logic              ilv,
    input  logic              is_write,
    input  logic              wr_single,
    output logic [COL_W-1:0]  base_q,
    output logic [BEAT_W-1:0] mask_q,
    output logic [BEAT_W-1:0] beat_q,
    output logic              ilv_q,
    output logic              valid,
    output logic              last
);
    seq_state_t state, nxt;
    logic       at_end;

    assign at_end = (beat_q == mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_BURST;
            end
            ST_BURST: begin
                if (start)              nxt = ST_BURST;
                else if (term || at_end) nxt = ST_IDLE;
                else                    nxt = ST_BURST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            beat_q <= '0;
            ilv_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            mask_q <= dec_mask;
            beat_q <= '0;
            ilv_q  <= ilv;
        end else if (state == ST_BURST) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        valid = (state == ST_BURST);
        last  = (state == ST_BURST) && at_end;
    end

    // R3
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    // R3
    end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !valid);

    // R6
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && term && !start) |=> !valid);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && beat_q == '0));

    // R9
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_write && wr_single) |=> last);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_code,
    input  logic             ilv,
    input  logic             is_write,
    input  logic             wr_single,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             last
);
    logic [BEAT_W-1:0] dec_mask;
    logic [COL_W-1:0]  base_q;
    logic [BEAT_W-1:0] mask_q;
    logic [BEAT_W-1:0] beat_q;
    logic              ilv_q;

    burst_len_dec u_dec (
        .len_code  (len_code),
        .is_write  (is_write),
        .wr_single (wr_single),
        .wrap_mask (dec_mask)
    );

    burst_col_fsm #(.COL_W(COL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .term      (term),
        .start_col (start_col),
        .dec_mask  (dec_mask),
        .ilv       (ilv),
        .is_write  (is_write),
        .wr_single (wr_single),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .beat_q    (beat_q),
        .ilv_q     (ilv_q),
        .valid     (valid),
        .last      (last)
    );

    burst_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_col  (base_q),
        .wrap_mask (mask_q),
        .beat      (beat_q),
        .ilv       (ilv_q),
        .col       (col)
    );

    // R4
    col_hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid) && !$past(start)) |-> $stable(col[COL_W-1:BEAT_W]));

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col == $past(start_col)));
endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             term = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [1:0]       len_code = 2'b00;
    logic             ilv = 1'b0;
    logic             is_write = 1'b0;
    logic             wr_single = 1'b0;
    logic [COL_W-1:0] col;
    logic             valid;
    logic             last;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .term(term),
        .start_col(start_col), .len_code(len_code), .ilv(ilv),
        .is_write(is_write), .wr_single(wr_single),
        .col(col), .valid(valid), .last(last)
    );

    function automatic int exp_col(int base, int code, bit order, int beat);
        int n = 1 << code;
        int m = n - 1;
        int low = order ? ((base ^ beat) & m) : ((base + beat) & m);
        return (base & ~m) | low;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic scramble();
        start_col = COL_W'($urandom);
        len_code  = 2'($urandom);
        ilv       = 1'($urandom);
        is_write  = 1'($urandom);
        wr_single = 1'($urandom);
    endtask

    // Launch at a negedge, then check each beat at later negedges.
    task automatic run_burst(int base, int code, bit order, bit wr, bit ws,
                             int term_at, string req);
        int eff = (wr && ws) ? 0 : code;
        int n = 1 << eff;
        start_col = COL_W'(base); len_code = 2'(code); ilv = order;
        is_write = wr; wr_single = ws; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scramble();  // R10: inputs after capture must not matter
        for (int b = 0; b < n; b++) begin
            check({req, " valid"}, valid, 1);
            check({req, " col"}, col, exp_col(base, eff, order, b));
            check({req, " last"}, last, (b == n - 1) ? 1 : 0);
            if (b == term_at && b < n - 1) begin
                term = 1'b1;
                @(negedge clk);
                term = 1'b0;
                check("R6 valid after term", valid, 0);
                check("R6 last after term", last, 0);
                return;
            end
            @(negedge clk);
            scramble();
        end
        check({req, " valid after end"}, valid, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        check("R1 valid in reset", valid, 0);
        check("R1 last in reset", last, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", valid, 0);

        // R7: terminate while idle
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        check("R7 idle term", valid, 0);
        @(negedge clk);
        check("R7 idle term later", valid, 0);

        // Directed orderings
        run_burst(5, 2, 0, 0, 0, 99, "R4 seq 5-6-7-4");
        run_burst(5, 2, 1, 0, 0, 99, "R5 ilv 5-4-7-6");
        run_burst(8, 3, 0, 0, 0, 99, "R5 aligned seq");
        run_burst(8, 3, 1, 0, 0, 99, "R5 aligned ilv");
        run_burst(7, 2, 0, 0, 0, 99, "R4 top of block");
        run_burst(13, 1, 1, 0, 0, 99, "R3 len2");
        run_burst(22, 0, 0, 0, 0, 99, "R3 len1");
        run_burst(1023, 3, 0, 0, 0, 99, "R4 top column");
        run_burst(6, 3, 1, 1, 1, 99, "R9 forced write");
        run_burst(6, 3, 1, 1, 0, 99, "R9 normal write");
        run_burst(6, 3, 1, 0, 1, 99, "R9 read ignores");
        run_burst(3, 3, 0, 0, 0, 2, "R6 term mid");

        // R8: restart during a burst, colliding with terminate
        start_col = 10'd17; len_code = 2'b11; ilv = 1'b0;
        is_write = 1'b0; wr_single = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start_col = 10'd42; len_code = 2'b10; ilv = 1'b1;
        start = 1'b1; term = 1'b1;
        @(negedge clk);
        start = 1'b0; term = 1'b0;
        check("R8 restart valid", valid, 1);
        check("R8 restart col", col, 42);
        @(negedge clk);
        check("R8 restart beat1", col, exp_col(42, 2, 1, 1));
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        check("R6 term after restart", valid, 0);

        // Constrained random bursts
        for (int i = 0; i < 400; i++) begin
            int base = int'($urandom_range(0, 1023));
            int code = int'($urandom_range(0, 3));
            bit order = 1'($urandom);
            bit wr = 1'($urandom);
            bit ws = 1'($urandom);
            int ta = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : 99;
            run_burst(base, code, order, wr, ws, ta, "R4 R5 R10 random");
            if ($urandom_range(0, 1) == 1) @(negedge clk);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule